// File: doc/BRIEF.md
# Block-Transfer Start Address Counter

This block keeps the low eight bits of the address that a bus master uses for a block transfer. It also decides where the counter's start value comes from. Two active-low strobes announce a transfer: a master-write-block strobe and a block-transfer strobe. The block watches which of the two becomes active first.

If the write-block strobe leads, or both strobes arrive in the same clock, the counter starts from the local address byte. If the block-transfer strobe leads, the counter starts from a staging byte. That byte was filled earlier by a separate local strobe cycle, which is qualified by a select line and by the write-block strobe.

While a transfer is running, every data-beat pulse advances the counter by one, and the count wraps at 256. A flag reports that the current count came from the staging byte. Such a count is not a valid address for a single-cycle transfer. All asynchronous controls pass through two-flop synchronizers before the block uses them.

Top module: `blk_addr_loader`

## Requirements
- R1: While reset is held and after it is released, `cnt` reads 0x00, `cnt_from_stage` reads 0 and `blk_active` reads 0.
- R2: When `wblk_n` goes low before `xfer_n`, the counter loads `laddr`. `cnt_from_stage` is then 0 and `blk_active` is 1. Both effects appear three clock edges after the later strobe falls.
- R3: When both strobes fall in the same clock, the counter loads `laddr` and `cnt_from_stage` is 0.
- R4: When `xfer_n` goes low before `wblk_n`, the counter loads the staging byte and `cnt_from_stage` is 1. A value of 1 marks the count as unusable for single-cycle transfers, and the flag does not change while the transfer is active.
- R5: A staging cycle captures `ldata` into the staging byte when `lstb_n` rises, provided that `lsel` was 1 and `wblk_n` was 0 when `lstb_n` fell.
- R6: A cycle on `lstb_n` that starts with `lsel` at 0, or with `wblk_n` at 1, leaves the staging byte unchanged.
- R7: While `blk_active` is 1, each clock with `beat` at 1 adds one to `cnt`, and 0xFF steps to 0x00.
- R8: While `blk_active` is 0, `beat` has no effect on `cnt`.
- R9: Once both strobes are high again, `blk_active` drops to 0 and the order detector is ready for the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wblk_n | input | 1 | Master-write-block strobe, active low, asynchronous |
| xfer_n | input | 1 | Block-transfer strobe, active low, asynchronous |
| lsel | input | 1 | Local select qualifying a staging cycle |
| lstb_n | input | 1 | Local strobe for staging cycles, active low |
| laddr | input | 8 | Local address byte, used for the normal-order start value |
| ldata | input | 8 | Local data byte, captured into the staging byte |
| beat | input | 1 | Synchronous data-beat pulse |
| cnt | output | 8 | Current low address count |
| cnt_from_stage | output | 1 | Count was loaded from the staging byte |
| blk_active | output | 1 | A block transfer is in progress |

## Verification
The staging byte and the order detector cannot be seen directly. Any fault in them shows up at the next transfer whose block-transfer strobe leads: `cnt` and `cnt_from_stage` take wrong values three edges after the second strobe falls.

A counter or enable fault shows on the clock after a beat. An order detector stuck in its run state shows as `blk_active` still high three edges after both strobes are released.

The bench therefore reads the staging byte back through block-transfer-first transfers. It checks each stage at those fixed distances.

// File: rtl/blk_addr_pkg.sv
package blk_addr_pkg;
  typedef enum logic [1:0] {
    ORD_IDLE   = 2'd0,
    ORD_WFIRST = 2'd1,
    ORD_XFIRST = 2'd2,
    ORD_RUN    = 2'd3
  } ord_state_t;
endpackage

// File: rtl/blk_sync.sv
module blk_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] sr_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) sr_q[i] <= RST_VAL;
    end else begin
      sr_q[0] <= d;
      for (int i = 1; i < STAGES; i++) sr_q[i] <= sr_q[i-1];
    end
  end

  assign q = sr_q[STAGES-1];
endmodule

// File: rtl/blk_order_det.sv
module blk_order_det
  import blk_addr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wblk_act,
  input  logic xfer_act,
  output logic ld_addr,
  output logic ld_stage,
  output logic run
);
  ord_state_t state_q, state_d;

  always_comb begin
    state_d  = state_q;
    ld_addr  = 1'b0;
    ld_stage = 1'b0;
    unique case (state_q)
      ORD_IDLE: begin
        if (wblk_act && xfer_act) begin
          ld_addr = 1'b1;
          state_d = ORD_RUN;
        end else if (wblk_act) begin
          state_d = ORD_WFIRST;
        end else if (xfer_act) begin
          state_d = ORD_XFIRST;
        end
      end
      ORD_WFIRST: begin
        if (wblk_act && xfer_act) begin
          ld_addr = 1'b1;
          state_d = ORD_RUN;
        end else if (!wblk_act) begin
          state_d = xfer_act ? ORD_XFIRST : ORD_IDLE;
        end
      end
      ORD_XFIRST: begin
        if (wblk_act && xfer_act) begin
          ld_stage = 1'b1;
          state_d  = ORD_RUN;
        end else if (!xfer_act) begin
          state_d = wblk_act ? ORD_WFIRST : ORD_IDLE;
        end
      end
      ORD_RUN: begin
        if (!wblk_act && !xfer_act) state_d = ORD_IDLE;
      end
      default: state_d = ORD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ORD_IDLE;
    else        state_q <= state_d;
  end

  assign run = (state_q == ORD_RUN);
endmodule

// File: rtl/blk_stage_latch.sv
module blk_stage_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb_act,
  input  logic         sel,
  input  logic         wblk_act,
  input  logic [W-1:0] din,
  output logic [W-1:0] stage
);
  logic         stb_prev_q;
  logic         armed_q, armed_d;
  logic [W-1:0] stage_q, stage_d;
  logic         stb_fall, stb_rise, stage_en;

  assign stb_fall = stb_act && !stb_prev_q;
  assign stb_rise = !stb_act && stb_prev_q;
  assign stage_en = stb_rise && armed_q;

  always_comb begin
    armed_d = armed_q;
    if (stb_fall)      armed_d = sel && wblk_act;
    else if (stb_rise) armed_d = 1'b0;
    stage_d = stage_q;
    if (stage_en) stage_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_prev_q <= 1'b0;
      armed_q    <= 1'b0;
      stage_q    <= '0;
    end else begin
      stb_prev_q <= stb_act;
      armed_q    <= armed_d;
      if (stage_en) stage_q <= stage_d;
    end
  end

  assign stage = stage_q;
endmodule

// File: rtl/blk_beat_ctr.sv
module blk_beat_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_addr,
  input  logic         ld_stage,
  input  logic         run,
  input  logic         beat,
  input  logic [W-1:0] addr_val,
  input  logic [W-1:0] stage_val,
  output logic [W-1:0] cnt,
  output logic         from_stage
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         src_q, src_d;
  logic         cnt_en;

  assign cnt_en = ld_addr || ld_stage || (run && beat);

  always_comb begin
    cnt_d = cnt_q;
    src_d = src_q;
    if (ld_addr) begin
      cnt_d = addr_val;
      src_d = 1'b0;
    end else if (ld_stage) begin
      cnt_d = stage_val;
      src_d = 1'b1;
    end else if (run && beat) begin
      cnt_d = cnt_q + {{(W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      src_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      src_q <= src_d;
    end
  end

  assign cnt        = cnt_q;
  assign from_stage = src_q;
endmodule

// File: rtl/blk_addr_loader.sv
module blk_addr_loader #(
  parameter int AW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wblk_n,
  input  logic          xfer_n,
  input  logic          lsel,
  input  logic          lstb_n,
  input  logic [AW-1:0] laddr,
  input  logic [AW-1:0] ldata,
  input  logic          beat,
  output logic [AW-1:0] cnt,
  output logic          cnt_from_stage,
  output logic          blk_active
);
  localparam int NCTL = 4;

  logic [1:0]      rst_sr_q;
  logic            rst_int_n;
  logic [NCTL-1:0] ctl_raw, ctl_sync;
  logic            wblk_act, xfer_act, stb_act, sel_s;
  logic            ld_addr, ld_stage, run;
  logic [AW-1:0]   stage_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sr_q <= 2'b00;
    else        rst_sr_q <= {rst_sr_q[0], 1'b1};
  end
  assign rst_int_n = rst_sr_q[1];

  assign ctl_raw = {lsel, lstb_n, xfer_n, wblk_n};

  blk_sync #(.W(NCTL), .STAGES(SYNC_STAGES), .RST_VAL(4'b0111)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (ctl_raw),
    .q     (ctl_sync)
  );

  assign wblk_act = !ctl_sync[0];
  assign xfer_act = !ctl_sync[1];
  assign stb_act  = !ctl_sync[2];
  assign sel_s    = ctl_sync[3];

  blk_order_det u_order (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wblk_act (wblk_act),
    .xfer_act (xfer_act),
    .ld_addr  (ld_addr),
    .ld_stage (ld_stage),
    .run      (run)
  );

  blk_stage_latch #(.W(AW)) u_stage (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .stb_act  (stb_act),
    .sel      (sel_s),
    .wblk_act (wblk_act),
    .din      (ldata),
    .stage    (stage_val)
  );

  blk_beat_ctr #(.W(AW)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .ld_addr    (ld_addr),
    .ld_stage   (ld_stage),
    .run        (run),
    .beat       (beat),
    .addr_val   (laddr),
    .stage_val  (stage_val),
    .cnt        (cnt),
    .from_stage (cnt_from_stage)
  );

  assign blk_active = run;
endmodule

// File: rtl/blk_addr_loader_chk.sv
module blk_addr_loader_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] laddr,
  input logic          beat,
  input logic [AW-1:0] cnt,
  input logic          cnt_from_stage,
  input logic          blk_active
);
  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    blk_active && beat |=> cnt == $past(cnt) + 1'b1); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_active && $past(!blk_active) |-> $stable(cnt)); // R8

  AST_SRC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    blk_active && $past(blk_active) |-> $stable(cnt_from_stage)); // R4

  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blk_active) && !cnt_from_stage |-> cnt == $past(laddr)); // R2

  AST_RESET_VAL: assert property (@(posedge clk)
    !rst_n |-> cnt == '0 && !blk_active && !cnt_from_stage); // R1
endmodule

bind blk_addr_loader blk_addr_loader_chk #(.AW(AW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .laddr          (laddr),
  .beat           (beat),
  .cnt            (cnt),
  .cnt_from_stage (cnt_from_stage),
  .blk_active     (blk_active)
);

// File: tb/blk_addr_loader_bench.sv
module blk_addr_loader_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wblk_n, xfer_n, lsel, lstb_n, beat;
  logic [7:0] laddr, ldata;
  logic [7:0] cnt;
  logic       cnt_from_stage, blk_active;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  bit          done  = 1'b0;

  logic [7:0] m_stage, m_cnt;
  logic       m_src;

  always #10 clk = ~clk;

  blk_addr_loader u_blk_addr_loader (
    .clk(clk), .rst_n(rst_n), .wblk_n(wblk_n), .xfer_n(xfer_n),
    .lsel(lsel), .lstb_n(lstb_n), .laddr(laddr), .ldata(ldata),
    .beat(beat), .cnt(cnt), .cnt_from_stage(cnt_from_stage),
    .blk_active(blk_active)
  );

  function automatic logic [7:0] f_step(input logic [7:0] v, input int n);
    return 8'((int'(v) + n) % 256);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic stage_cycle(input logic s, input logic wlow, input logic [7:0] d);
    lsel = s; wblk_n = !wlow; xfer_n = 1'b1;
    settle();
    lstb_n = 1'b0;
    settle();
    ldata = d;
    @(negedge clk);
    lstb_n = 1'b1;
    settle();
    wblk_n = 1'b1; lsel = 1'b0;
    settle();
    if (s && wlow) m_stage = d;
  endtask

  // order: 0 write-block first, 1 block-transfer first, 2 same clock
  task automatic start_xfer(input int order, input logic [7:0] a);
    laddr = a;
    if (order == 0) begin
      wblk_n = 1'b0; settle(); xfer_n = 1'b0;
    end else if (order == 1) begin
      xfer_n = 1'b0; settle(); wblk_n = 1'b0;
    end else begin
      wblk_n = 1'b0; xfer_n = 1'b0;
    end
    settle();
    m_cnt = (order == 1) ? m_stage : a;
    m_src = (order == 1);
    chk(order == 1 ? "R4 cnt" : (order == 2 ? "R3 cnt" : "R2 cnt"), cnt, m_cnt);
    chk(order == 1 ? "R4 flag" : "R2_R3 flag", cnt_from_stage, m_src);
    chk("R2 active", blk_active, 1'b1);
  endtask

  task automatic run_beats(input int n);
    for (int i = 0; i < n; i++) begin
      beat = 1'b1;
      @(negedge clk);
      beat = ($urandom_range(0, 3) == 0);
      if (beat) begin
        @(negedge clk);
        m_cnt = f_step(m_cnt, 1);
      end
      beat = 1'b0;
      m_cnt = f_step(m_cnt, 1);
    end
    @(negedge clk);
    chk("R7 count", cnt, m_cnt);
    chk("R4 flag held", cnt_from_stage, m_src);
  endtask

  task automatic end_xfer();
    wblk_n = 1'b1; xfer_n = 1'b1;
    settle();
    chk("R9 idle", blk_active, 1'b0);
  endtask

  task automatic idle_beats();
    for (int i = 0; i < 6; i++) begin
      beat = 1'b1; @(negedge clk);
    end
    beat = 1'b0; @(negedge clk);
    chk("R8 cnt", cnt, m_cnt);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; wblk_n = 1'b1; xfer_n = 1'b1; lsel = 1'b0; lstb_n = 1'b1;
    beat = 1'b0; laddr = 8'h00; ldata = 8'h00;
    m_stage = 8'h00; m_cnt = 8'h00; m_src = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 cnt in reset", cnt, 8'h00);
    chk("R1 active in reset", blk_active, 1'b0);
    rst_n = 1'b1;
    settle();
    chk("R1 cnt", cnt, 8'h00);
    chk("R1 flag", cnt_from_stage, 1'b0);
    chk("R1 active", blk_active, 1'b0);

    start_xfer(0, 8'h3C); run_beats(3); end_xfer();
    start_xfer(2, 8'hA5); run_beats(1); end_xfer();
    stage_cycle(1'b1, 1'b1, 8'hFF);
    start_xfer(1, 8'h11);
    chk("R5 stage load", cnt, 8'hFF);
    run_beats(1);
    chk("R7 wrap", cnt, m_cnt);
    end_xfer();
    idle_beats();
    stage_cycle(1'b0, 1'b1, 8'h55);
    start_xfer(1, 8'h22); chk("R6 sel low", cnt, 8'hFF); end_xfer();
    stage_cycle(1'b1, 1'b0, 8'h66);
    start_xfer(1, 8'h33); chk("R6 wblk high", cnt, 8'hFF); end_xfer();

    for (int it = 0; it < 40; it++) begin
      if ($urandom_range(0, 1) == 1)
        stage_cycle(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 8'($urandom));
      start_xfer(int'($urandom_range(0, 2)), 8'($urandom));
      run_beats(int'($urandom_range(0, 120)));
      end_xfer();
      if ($urandom_range(0, 3) == 0) idle_beats();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule